// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the start-up and the keep-alive traffic of an asynchronous DRAM with 1024 rows. Once reset is released it keeps every strobe idle for a fixed settling time. It then runs a burst of eight CAS-before-RAS cycles, and after that it raises `init_done` so that the access controller may begin normal work. From then on, an interval timer sets one refresh due in each slice of the refresh period, so that all rows are covered inside the period. Both the period and the clock rate are parameters.

The block shares the DRAM strobes with the access controller. It raises `ref_req` while it has refresh work, and it drives the pins only while `ref_gnt` is high. The controller grants only when it is idle with its page closed. It keeps the grant high until `ref_req` falls. Refreshes that fall due while the grant is withheld are queued up to a small bound. They are then run back to back in a single grant. Because the DRAM's own row counter picks the row, the block drives no address.

The interface is plain control pins. There is no data stream, and so no valid/ready pair.

Top module: `dram_refresh_seq`

## Requirements
- R1: For WAIT_US·CLK_MHZ clock cycles after reset (20000 with defaults), `ref_req` and `init_done` stay low and all four DRAM strobes stay high, whatever the controller pins carry. `ref_req` first goes high about that many cycles after reset (within one cycle).
- R2: After the wait, exactly eight CAS-before-RAS cycles are issued before `init_done` goes high. `init_done` then stays high until reset.
- R3: In every refresh cycle, both CAS strobes are low at least one clock before `dram_ras_n` falls. `dram_we_n` stays high while the grant is held.
- R4: A refresh cycle keeps RAS low for at least ceil(60 ns·CLK_MHZ/1000) cycles (6) and closes with both CAS strobes high when RAS rises. Successive RAS falls are at least ceil(104 ns·CLK_MHZ/1000) cycles apart (11).
- R5: After `init_done`, one refresh falls due every floor(PERIOD_MS·1000·CLK_MHZ/1024) cycles (1562). With the grant given at once, successive rises of `ref_req` lie exactly that far apart.
- R6: Refreshes that fall due while the grant is withheld are queued. Once granted, they all run inside one continuous `ref_req` assertion, back to back, each cycle taking at most one idle clock between them.
- R7: The queue holds at most PEND_MAX (4) refreshes. Further refreshes that fall due while the queue is full are dropped.
- R8: While `ref_gnt` is low and `init_done` is high, each DRAM strobe equals the matching controller pin.
- R9: A refresh cycle starts only while `ref_gnt` is high, and `ref_req` stays high until the cycle in progress has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_MHZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Pin ownership granted by the access controller |
| ctrl_ras_n | input | 1 | Controller RAS strobe |
| ctrl_lcas_n | input | 1 | Controller lower-byte CAS strobe |
| ctrl_ucas_n | input | 1 | Controller upper-byte CAS strobe |
| ctrl_we_n | input | 1 | Controller write enable |
| ref_req | output | 1 | Refresh work pending or in progress |
| init_done | output | 1 | Power-up sequence complete |
| dram_ras_n | output | 1 | RAS strobe to the DRAM |
| dram_lcas_n | output | 1 | Lower CAS strobe to the DRAM |
| dram_ucas_n | output | 1 | Upper CAS strobe to the DRAM |
| dram_we_n | output | 1 | Write enable to the DRAM |

## Verification
The properties assume that the controller raises `ref_gnt` only in answer to `ref_req`, and that it keeps the grant high until `ref_req` falls. Under that assumption, a refresh cycle in progress never loses its pins. The bench models the grant as a copy of `ref_req` taken one half-clock later, or it holds the grant low for whole intervals. It never drops the grant in the middle of a cycle. It toggles the controller strobes only while the grant is low.

// File: rtl/drs_pkg.sv
package drs_pkg;
  typedef enum logic [1:0] {SEQ_WAIT, SEQ_INIT, SEQ_RUN} seq_e;
  typedef enum logic [1:0] {PH_IDLE, PH_CAS, PH_RAS, PH_PRE} cbr_ph_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/drs_ticker.sv
module drs_ticker #(
  parameter int LIMIT = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/drs_pending.sv
module drs_pending #(
  parameter int MAXV = 4,
  localparam int PW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] count,
  output logic          nonzero
);
  logic full;
  assign full    = (count == PW'(MAXV));
  assign nonzero = (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else begin
      case ({inc && !full, dec && nonzero})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine import drs_pkg::*; #(
  parameter int CAS_CYC = 1,
  parameter int RAS_CYC = 6,
  parameter int PRE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int LONGEST = (RAS_CYC > PRE_CYC) ? ((RAS_CYC > CAS_CYC) ? RAS_CYC : CAS_CYC)
                                               : ((PRE_CYC > CAS_CYC) ? PRE_CYC : CAS_CYC);
  localparam int CW = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  cbr_ph_e       ph;
  logic [CW-1:0] cnt;

  assign busy  = (ph != PH_IDLE);
  assign done  = (ph == PH_PRE) && (cnt == '0);
  assign cas_n = !((ph == PH_CAS) || (ph == PH_RAS));
  assign ras_n = !(ph == PH_RAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (ph == PH_IDLE) begin
      if (start) begin
        ph  <= PH_CAS;
        cnt <= CW'(CAS_CYC - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (ph)
        PH_CAS:  begin ph <= PH_RAS; cnt <= CW'(RAS_CYC - 1); end
        PH_RAS:  begin ph <= PH_PRE; cnt <= CW'(PRE_CYC - 1); end
        default: begin ph <= PH_IDLE; cnt <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq import drs_pkg::*; #(
  parameter int ROWS        = 1024,
  parameter int CLK_MHZ     = 100,
  parameter int PERIOD_MS   = 16,
  parameter int WAIT_US     = 200,
  parameter int INIT_CYCLES = 8,
  parameter int PEND_MAX    = 4,
  parameter int TRC_NS      = 104,
  parameter int TRAS_NS     = 60,
  parameter int TRP_NS      = 40,
  parameter int CAS_LEAD    = 1,
  localparam int PW         = $clog2(PEND_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic ctrl_ras_n,
  input  logic ctrl_lcas_n,
  input  logic ctrl_ucas_n,
  input  logic ctrl_we_n,
  output logic ref_req,
  output logic init_done,
  output logic dram_ras_n,
  output logic dram_lcas_n,
  output logic dram_ucas_n,
  output logic dram_we_n
);
  localparam int WAIT_CYC = WAIT_US * CLK_MHZ;
  localparam int INTERVAL = (PERIOD_MS * 1000 * CLK_MHZ) / ROWS;
  localparam int RAS_CYC  = ns_to_cyc(TRAS_NS, CLK_MHZ);
  localparam int TRC_CYC  = ns_to_cyc(TRC_NS, CLK_MHZ);
  localparam int PRE_MIN  = ns_to_cyc(TRP_NS, CLK_MHZ);
  localparam int PRE_FILL = TRC_CYC - CAS_LEAD - RAS_CYC;
  localparam int PRE_CYC  = (PRE_FILL > PRE_MIN) ? PRE_FILL : ((PRE_MIN > 0) ? PRE_MIN : 1);
  localparam int IW       = $clog2(INIT_CYCLES + 1);

  seq_e          seq;
  logic [IW-1:0] init_issued, init_closed;
  logic          wait_tick, ref_tick;
  logic          want, start;
  logic          eng_busy, eng_done, eng_ras_n, eng_cas_n;
  logic [PW-1:0] pend_cnt;
  logic          pend_nz;

  drs_ticker #(.LIMIT(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .en(seq == SEQ_WAIT), .tick(wait_tick));

  drs_ticker #(.LIMIT(INTERVAL)) u_period (
    .clk(clk), .rst_n(rst_n), .en(seq == SEQ_RUN), .tick(ref_tick));

  drs_pending #(.MAXV(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(ref_tick), .dec(start && (seq == SEQ_RUN)),
    .count(pend_cnt), .nonzero(pend_nz));

  drs_cbr_engine #(.CAS_CYC(CAS_LEAD), .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(eng_busy), .done(eng_done),
    .ras_n(eng_ras_n), .cas_n(eng_cas_n));

  assign want = ((seq == SEQ_INIT) && (init_issued != IW'(INIT_CYCLES)))
             || ((seq == SEQ_RUN) && pend_nz);
  assign start     = want && ref_gnt && !eng_busy;
  assign ref_req   = want || eng_busy;
  assign init_done = (seq == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq         <= SEQ_WAIT;
      init_issued <= '0;
      init_closed <= '0;
    end else begin
      case (seq)
        SEQ_WAIT: if (wait_tick) seq <= SEQ_INIT;
        SEQ_INIT: begin
          if (start) init_issued <= init_issued + 1'b1;
          if (eng_done) begin
            init_closed <= init_closed + 1'b1;
            if (init_closed == IW'(INIT_CYCLES - 1)) seq <= SEQ_RUN;
          end
        end
        default: seq <= SEQ_RUN;
      endcase
    end
  end

  // pin ownership: granted -> refresh engine; not yet started -> idle; else controller
  always_comb begin
    if (ref_gnt) begin
      dram_ras_n  = eng_ras_n;
      dram_lcas_n = eng_cas_n;
      dram_ucas_n = eng_cas_n;
      dram_we_n   = 1'b1;
    end else if (!init_done) begin
      dram_ras_n  = 1'b1;
      dram_lcas_n = 1'b1;
      dram_ucas_n = 1'b1;
      dram_we_n   = 1'b1;
    end else begin
      dram_ras_n  = ctrl_ras_n;
      dram_lcas_n = ctrl_lcas_n;
      dram_ucas_n = ctrl_ucas_n;
      dram_we_n   = ctrl_we_n;
    end
  end
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
  parameter int PEND_MAX = 4,
  parameter int PW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          init_done,
  input logic          dram_ras_n,
  input logic          dram_lcas_n,
  input logic          dram_ucas_n,
  input logic          dram_we_n,
  input logic          eng_busy,
  input logic [PW-1:0] pend_cnt
);
  assert_quiet_before_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !ref_gnt) |-> (dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n));

  assert_init_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && $fell(dram_ras_n)) |-> (!$past(dram_lcas_n) && !$past(dram_ucas_n)));

  assert_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> dram_we_n);

  assert_cycle_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && $rose(dram_ras_n)) |-> (dram_lcas_n && dram_ucas_n));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(PEND_MAX));

  assert_busy_holds_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (ref_req && ref_gnt));
endmodule

bind dram_refresh_seq drs_checker #(.PEND_MAX(PEND_MAX), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .init_done(init_done), .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n),
  .dram_ucas_n(dram_ucas_n), .dram_we_n(dram_we_n), .eng_busy(eng_busy),
  .pend_cnt(pend_cnt));

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 200 * 100;
  localparam int INTV       = (16 * 1000 * 100) / 1024;
  localparam int TRC        = (104 * 100 + 999) / 1000;
  localparam int TRAS       = (60 * 100 + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0;
  logic ctrl_ras_n = 1'b1, ctrl_lcas_n = 1'b1, ctrl_ucas_n = 1'b1, ctrl_we_n = 1'b1;
  logic ref_req, init_done, dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n;
  int checks = 0, errors = 0, cyc = 0;
  int ras_falls = 0, last_fall = -1000, low_start = 0;
  logic chk_on = 1'b1, p_ras = 1'b1, p_lcas = 1'b1, p_ucas = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt),
    .ctrl_ras_n(ctrl_ras_n), .ctrl_lcas_n(ctrl_lcas_n), .ctrl_ucas_n(ctrl_ucas_n),
    .ctrl_we_n(ctrl_we_n), .ref_req(ref_req), .init_done(init_done),
    .dram_ras_n(dram_ras_n), .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
    .dram_we_n(dram_we_n));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // pin monitor, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (chk_on && rst_n) begin
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        chk(!p_lcas && !p_ucas, "R3 cas low before ras", {p_lcas, p_ucas}, 0);
        chk(dram_we_n, "R3 we high", dram_we_n, 1);
        chk(cyc - last_fall >= TRC, "R4 ras-to-ras spacing", cyc - last_fall, TRC);
        last_fall = cyc;
        low_start = cyc;
      end
      if (!p_ras && dram_ras_n) begin
        chk(dram_lcas_n && dram_ucas_n, "R4 cas high at close", {dram_lcas_n, dram_ucas_n}, 3);
        chk(cyc - low_start >= TRAS, "R4 ras low width", cyc - low_start, TRAS);
      end
    end
    p_ras = dram_ras_n; p_lcas = dram_lcas_n; p_ucas = dram_ucas_n;
  end

  task automatic serve(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); ref_gnt = ref_req; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ref_req && !init_done, "R1 reset outputs", {ref_req, init_done}, 0);
    chk(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n, "R1 reset pins", 0, 15);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup_wait();
    int n = 0;
    logic quiet = 1'b1;
    ctrl_ras_n = 1'b0; ctrl_lcas_n = 1'b0; ctrl_ucas_n = 1'b0; ctrl_we_n = 1'b0;
    while (n < WAIT_CYC + 50) begin
      @(negedge clk);
      if (ref_req) break;
      n++;
      if (!(dram_ras_n && dram_lcas_n && dram_ucas_n && dram_we_n) || init_done) quiet = 1'b0;
    end
    chk(quiet, "R1 pins idle during wait", quiet, 1);
    chk(n >= WAIT_CYC - 1 && n <= WAIT_CYC + 1, "R1 wait length", n, WAIT_CYC);
    ctrl_ras_n = 1'b1; ctrl_lcas_n = 1'b1; ctrl_ucas_n = 1'b1; ctrl_we_n = 1'b1;
  endtask

  task automatic t_init_burst();
    int f0 = ras_falls;
    int n = 0;
    while (!init_done && n < 400) begin serve(1); n++; end
    chk(init_done, "R2 init_done reached", init_done, 1);
    chk(ras_falls - f0 == 8, "R2 eight power-up cycles", ras_falls - f0, 8);
    serve(5);
    chk(init_done, "R2 init_done stays", init_done, 1);
  endtask

  task automatic t_mux();
    logic [3:0] pats [4] = '{4'b0101, 4'b1010, 4'b0011, 4'b1100};
    chk_on = 1'b0;
    ref_gnt = 1'b0;
    foreach (pats[i]) begin
      {ctrl_ras_n, ctrl_lcas_n, ctrl_ucas_n, ctrl_we_n} = pats[i];
      @(negedge clk);
      chk({dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n} == pats[i], "R8 pins follow controller",
          {dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n}, pats[i]);
    end
    {ctrl_ras_n, ctrl_lcas_n, ctrl_ucas_n, ctrl_we_n} = 4'b1111;
    @(negedge clk);
    chk_on = 1'b1;
  endtask

  task automatic wait_rise(output int at);
    logic prev = ref_req;
    at = -1;
    for (int i = 0; i < 3 * INTV; i++) begin
      @(negedge clk);
      if (ref_req && !prev) begin at = cyc; break; end
      prev = ref_req;
      ref_gnt = ref_req;
    end
  endtask

  task automatic t_period();
    int a, b, c;
    wait_rise(a);
    ref_gnt = ref_req;
    wait_rise(b);
    ref_gnt = ref_req;
    wait_rise(c);
    ref_gnt = ref_req;
    chk(b - a == INTV, "R5 refresh interval", b - a, INTV);
    chk(c - b == INTV, "R5 refresh interval repeat", c - b, INTV);
  endtask

  task automatic t_postpone(input int k, input int exp, input string tag);
    int at, f0, t0, n;
    wait_rise(at);
    ref_gnt = 1'b0;
    repeat ((k - 1) * INTV + INTV / 2) @(negedge clk);
    chk(ref_req, {tag, " request held while not granted"}, ref_req, 1);
    f0 = ras_falls; t0 = cyc; n = 0;
    ref_gnt = 1'b1;
    while (ref_req && n < 200) begin @(negedge clk); n++; end
    ref_gnt = 1'b0;
    repeat (2) @(negedge clk);
    chk(ras_falls - f0 == exp, {tag, " queued refresh count"}, ras_falls - f0, exp);
    chk(cyc - t0 <= exp * (TRC + 1) + 3, {tag, " back to back burst"}, cyc - t0, exp * (TRC + 1) + 3);
    chk(!ref_req, "R9 request drops after burst", ref_req, 0);
  endtask

  initial begin
    t_reset();
    t_powerup_wait();
    t_init_burst();
    t_mux();
    t_period();
    t_postpone(3, 3, "R6");
    t_postpone(6, 4, "R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule